// File: doc/BRIEF.md
# Status Register Bit Set/Clear Unit

This execute-stage unit belongs to a 32-bit soft processor. It holds the machine status word and serves two instructions that set or clear a chosen group of its bits in one step. A 15-bit immediate mask names the bits. The instruction can also return the status word, as it stood before the change, to a general register. The carry flag lives in its own flip-flop. It is shown twice in the status word: once at its home position and once at a mirror position in the top bit. A read-only flag position always reads as zero.

The unit takes an instruction word with a valid strobe and the current privilege level. In the same cycle it drives a register-file write port, a privilege-trap request and a pulse that tells downstream logic the processor state changed. The status word and the carry flag update on the next rising clock edge. User mode may change only the carry flag. Any other mask from user mode is refused with a trap and leaves everything as it was.

Top module: `msr_bitop_unit`

## Requirements
- R1: A word is accepted only when `issue_valid` is 1, bits 31:26 are 100101, and bits 20:15 are either 100010 (clear) or 100000 (set). Bits 25:21 name the destination register and bits 14:0 are the mask. Any other word, or a word without `issue_valid`, leaves every output and all state unchanged.
- R2: A set ORs the mask into the status word at the next rising edge. Bits 2 and 10 are removed from the mask first.
- R3: A clear ANDs the status word with the inverse of the mask at the next rising edge. Bits 2 and 10 are removed from the mask first.
- R4: When an accepted, untrapped instruction has a nonzero destination field, `rf_we` is 1 in the same cycle. `rf_waddr` equals the field and `rf_wdata` equals the status word from before the update. A zero destination field gives `rf_we` = 0.
- R5: When mask bit 2 is 1, the carry flag becomes 1 for a set and 0 for a clear. The status word shows the carry at bit 2 and again at bit 31.
- R6: In user mode (`user_mode` = 1), an accepted instruction whose mask is not exactly 0x0004 raises `priv_trap` in the same cycle. It makes no register write and changes neither the status word nor the carry.
- R7: In user mode, mask 0x0004 is allowed and changes only the carry flag.
- R8: Status bit 10 always reads 0. Bits 30:15 always read 0.
- R9: `state_changed` is 1 in the issue cycle exactly when the instruction is committed and its update changes some status bit other than the carry.
- R10: A synchronous active-high reset clears the status word and the carry flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| user_mode | input | 1 | 1 = user privilege, 0 = privileged |
| status_word | output | 32 | Current status word, carry merged in at bits 2 and 31 |
| carry_flag | output | 1 | Current carry flag |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | 32 | Register-file write data (status before the update) |
| priv_trap | output | 1 | Privilege trap request |
| state_changed | output | 1 | A status bit other than the carry is changing |

## Verification
The assertions check four things on every cycle:
- Refused or unrecognised words leave the status word and carry untouched.
- A set never drops a bit and a clear never raises one.
- The carry follows a mask that includes bit 2.
- A trap never writes the register file, and a state-change pulse is always followed by a real difference in the status word.

Exact result values come only from the bench's sequence, which starts from reset:
- set and clear masks that include the locked positions;
- the user-mode carry exception;
- a zero destination field;
- a repeated set that changes nothing;
- a reset in the middle of the run.

// File: rtl/msrop_pkg.sv
package msrop_pkg;
  localparam int XLEN      = 32;
  localparam int MASK_W    = 15;
  localparam int RD_W      = 5;
  localparam int OPC_W     = 6;
  localparam int SEL_W     = 6;
  localparam int CARRY_POS = 2;
  localparam int COPY_POS  = XLEN - 1;
  localparam int VER_POS   = 10;

  localparam int OPC_LSB = XLEN - OPC_W;
  localparam int RD_LSB  = OPC_LSB - RD_W;
  localparam int SEL_LSB = RD_LSB - SEL_W;

  localparam logic [OPC_W-1:0] OPC_BITOP = 6'b100101;
  localparam logic [SEL_W-1:0] SEL_CLR   = 6'b100010;
  localparam logic [SEL_W-1:0] SEL_SET   = 6'b100000;

  localparam logic [MASK_W-1:0] USER_MASK = MASK_W'(1) << CARRY_POS;
  localparam logic [MASK_W-1:0] LOCKED    = (MASK_W'(1) << CARRY_POS) | (MASK_W'(1) << VER_POS);

  typedef enum logic [1:0] {OP_NONE, OP_CLR, OP_SET} bitop_e;

  function automatic logic [MASK_W-1:0] strip_mask(input logic [MASK_W-1:0] m);
    return m & ~LOCKED;
  endfunction

  function automatic logic [MASK_W-1:0] apply_mask(input logic [MASK_W-1:0] body,
                                                   input logic [MASK_W-1:0] m,
                                                   input logic set);
    return set ? (body | m) : (body & ~m);
  endfunction

  function automatic logic [XLEN-1:0] compose_read(input logic [MASK_W-1:0] body,
                                                   input logic carry);
    logic [XLEN-1:0] r;
    r = '0;
    r[MASK_W-1:0] = body;
    r[VER_POS]    = 1'b0;
    r[CARRY_POS]  = carry;
    r[COPY_POS]   = carry;
    return r;
  endfunction
endpackage

// File: rtl/msrop_decode.sv
module msrop_decode
  import msrop_pkg::*;
(
  input  logic              valid,
  input  logic [XLEN-1:0]   word,
  output bitop_e            op,
  output logic [RD_W-1:0]   rd,
  output logic [MASK_W-1:0] mask
);
  logic [OPC_W-1:0] opc;
  logic [SEL_W-1:0] sel;

  assign opc  = word[OPC_LSB +: OPC_W];
  assign sel  = word[SEL_LSB +: SEL_W];
  assign rd   = word[RD_LSB +: RD_W];
  assign mask = word[MASK_W-1:0];

  always_comb begin
    op = OP_NONE;
    if (valid && opc == OPC_BITOP) begin
      if (sel == SEL_CLR)      op = OP_CLR;
      else if (sel == SEL_SET) op = OP_SET;
    end
  end
endmodule

// File: rtl/msrop_guard.sv
module msrop_guard
  import msrop_pkg::*;
(
  input  bitop_e            op,
  input  logic              user_mode,
  input  logic [MASK_W-1:0] mask,
  output logic              trap,
  output logic              commit
);
  logic hit;
  assign hit    = (op != OP_NONE);
  assign trap   = hit && user_mode && (mask != USER_MASK);
  assign commit = hit && !trap;
endmodule

// File: rtl/msrop_state.sv
module msrop_state
  import msrop_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  bitop_e            op,
  input  logic [MASK_W-1:0] mask,
  output logic [XLEN-1:0]   status_word,
  output logic              carry_q,
  output logic              changed
);
  logic [MASK_W-1:0] body_q;
  logic [MASK_W-1:0] body_nx;
  logic              is_set;

  assign is_set  = (op == OP_SET);
  assign body_nx = apply_mask(body_q, strip_mask(mask), is_set);
  assign changed = commit && (body_nx != body_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      body_q  <= '0;
      carry_q <= 1'b0;
    end else if (commit) begin
      body_q <= body_nx;
      if (mask[CARRY_POS]) carry_q <= is_set;
    end
  end

  assign status_word = compose_read(body_q, carry_q);
endmodule

// File: rtl/msr_bitop_unit.sv
module msr_bitop_unit
  import msrop_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_valid,
  input  logic [31:0]     instr_word,
  input  logic            user_mode,
  output logic [31:0]     status_word,
  output logic            carry_flag,
  output logic            rf_we,
  output logic [4:0]      rf_waddr,
  output logic [31:0]     rf_wdata,
  output logic            priv_trap,
  output logic            state_changed
);
  bitop_e            op_sel;
  logic [RD_W-1:0]   rd_fld;
  logic [MASK_W-1:0] mask_raw;
  logic              commit_en;

  msrop_decode u_dec (
    .valid (issue_valid),
    .word  (instr_word),
    .op    (op_sel),
    .rd    (rd_fld),
    .mask  (mask_raw)
  );

  msrop_guard u_grd (
    .op        (op_sel),
    .user_mode (user_mode),
    .mask      (mask_raw),
    .trap      (priv_trap),
    .commit    (commit_en)
  );

  msrop_state u_st (
    .clk         (clk),
    .rst         (rst),
    .commit      (commit_en),
    .op          (op_sel),
    .mask        (mask_raw),
    .status_word (status_word),
    .carry_q     (carry_flag),
    .changed     (state_changed)
  );

  // Old value leaves in the same cycle; the register still holds it
  assign rf_we    = commit_en && (rd_fld != '0);
  assign rf_waddr = rd_fld;
  assign rf_wdata = status_word;

  // R1: nothing accepted, nothing moves
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_NONE) |=> ($stable(status_word) && $stable(carry_flag)));

  // R2: set never lowers a non-carry bit
  p_set_keeps_r2: assert property (@(posedge clk) disable iff (rst)
    (commit_en && op_sel == OP_SET) |=>
      (($past(status_word) & ~status_word & ~(32'h8000_0004)) == 32'h0));

  // R3: clear never raises a non-carry bit
  p_clear_drops_r3: assert property (@(posedge clk) disable iff (rst)
    (commit_en && op_sel == OP_CLR) |=>
      ((status_word & ~$past(status_word) & ~(32'h8000_0004)) == 32'h0));

  // R4: zero destination suppresses the write
  p_rd0_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
    (instr_word[RD_LSB +: RD_W] == '0) |-> !rf_we);

  // R5: carry follows a mask that names it
  p_carry_follow_r5: assert property (@(posedge clk) disable iff (rst)
    (commit_en && mask_raw[CARRY_POS]) |=> (carry_flag == $past(op_sel == OP_SET)));

  // R6: a trap freezes state and blocks the write
  p_trap_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    priv_trap |=> ($stable(status_word) && $stable(carry_flag)));
  p_trap_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
    priv_trap |-> !rf_we);

  // R9: a change pulse is followed by a real difference
  p_changed_r9: assert property (@(posedge clk) disable iff (rst)
    state_changed |=> (status_word != $past(status_word)));
endmodule

// File: tb/sim_msr_bitop_unit.sv
module sim_msr_bitop_unit;
  localparam int CLK_P = 10;
  localparam int WDOG  = 5000;
  localparam int NV    = 13;

  typedef struct packed {
    logic        valid;
    logic        user;
    logic [31:0] word;
    logic        trap;
    logic        we;
    logic [31:0] wdata;
    logic        chg;
    logic [31:0] after;
  } vec_t;

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rd,
                                     input logic [5:0] sel, input logic [14:0] m);
    return {opc, rd, sel, m};
  endfunction

  localparam logic [5:0] OPC = 6'b100101;
  localparam logic [5:0] CLR = 6'b100010;
  localparam logic [5:0] SET = 6'b100000;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, mk(OPC, 5'd3,  SET, 15'h0102), 1'b0, 1'b1, 32'h0000_0000, 1'b1, 32'h0000_0102},
    '{1'b1, 1'b0, mk(OPC, 5'd0,  SET, 15'h0404), 1'b0, 1'b0, 32'h0000_0102, 1'b0, 32'h8000_0106},
    '{1'b1, 1'b1, mk(OPC, 5'd7,  SET, 15'h0008), 1'b1, 1'b0, 32'h8000_0106, 1'b0, 32'h8000_0106},
    '{1'b1, 1'b1, mk(OPC, 5'd5,  CLR, 15'h0004), 1'b0, 1'b1, 32'h8000_0106, 1'b0, 32'h0000_0102},
    '{1'b1, 1'b0, mk(OPC, 5'd1,  CLR, 15'h7FFF), 1'b0, 1'b1, 32'h0000_0102, 1'b1, 32'h0000_0000},
    '{1'b1, 1'b0, mk(OPC, 5'd31, SET, 15'h7FFF), 1'b0, 1'b1, 32'h0000_0000, 1'b1, 32'h8000_7BFF},
    '{1'b1, 1'b1, mk(OPC, 5'd2,  CLR, 15'h0000), 1'b1, 1'b0, 32'h8000_7BFF, 1'b0, 32'h8000_7BFF},
    '{1'b1, 1'b0, mk(OPC, 5'd4,  6'b100001, 15'h0001), 1'b0, 1'b0, 32'h8000_7BFF, 1'b0, 32'h8000_7BFF},
    '{1'b1, 1'b0, mk(OPC, 5'd6,  CLR, 15'h0010), 1'b0, 1'b1, 32'h8000_7BFF, 1'b1, 32'h8000_7BEF},
    '{1'b1, 1'b0, mk(OPC, 5'd9,  SET, 15'h0010), 1'b0, 1'b1, 32'h8000_7BEF, 1'b1, 32'h8000_7BFF},
    '{1'b1, 1'b0, mk(OPC, 5'd8,  SET, 15'h0010), 1'b0, 1'b1, 32'h8000_7BFF, 1'b0, 32'h8000_7BFF},
    '{1'b0, 1'b0, mk(OPC, 5'd3,  SET, 15'h0001), 1'b0, 1'b0, 32'h8000_7BFF, 1'b0, 32'h8000_7BFF},
    '{1'b1, 1'b0, mk(6'b100100, 5'd3, CLR, 15'h7FFF), 1'b0, 1'b0, 32'h8000_7BFF, 1'b0, 32'h8000_7BFF}
  };

  localparam string TAGS [NV] = '{
    "R2", "R5 R8", "R6", "R7", "R3", "R2 R8",
    "R6", "R1", "R3", "R2", "R9", "R1", "R1"
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        user_mode = 1'b0;
  logic [31:0] status_word;
  logic        carry_flag;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        priv_trap;
  logic        state_changed;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  msr_bitop_unit u0 (
    .clk           (clk),
    .rst           (rst),
    .issue_valid   (issue_valid),
    .instr_word    (instr_word),
    .user_mode     (user_mode),
    .status_word   (status_word),
    .carry_flag    (carry_flag),
    .rf_we         (rf_we),
    .rf_waddr      (rf_waddr),
    .rf_wdata      (rf_wdata),
    .priv_trap     (priv_trap),
    .state_changed (state_changed)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d cycles", WDOG, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: state after reset
    chk("R10", "status", status_word, 32'h0);
    chk("R10", "carry", {31'b0, carry_flag}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      issue_valid = VECS[i].valid;
      user_mode   = VECS[i].user;
      instr_word  = VECS[i].word;
      #1;
      chk(TAGS[i], "trap R6", {31'b0, priv_trap}, {31'b0, VECS[i].trap});
      chk(TAGS[i], "we R4", {31'b0, rf_we}, {31'b0, VECS[i].we});
      if (VECS[i].we) begin
        chk(TAGS[i], "waddr R4", {27'b0, rf_waddr}, {27'b0, VECS[i].word[25:21]});
        chk(TAGS[i], "wdata R4", rf_wdata, VECS[i].wdata);
      end
      chk(TAGS[i], "changed R9", {31'b0, state_changed}, {31'b0, VECS[i].chg});
      @(posedge clk);
      #1;
      chk(TAGS[i], "status", status_word, VECS[i].after);
      chk(TAGS[i], "carry R5", {31'b0, carry_flag}, {31'b0, VECS[i].after[2]});
    end

    // R8: locked flag position after an all-ones set
    @(negedge clk);
    issue_valid = 1'b0;
    chk("R8", "bit10", {31'b0, status_word[10]}, 32'h0);

    // R10: reset in the middle of the run clears everything
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    chk("R10", "status mid", status_word, 32'h0);
    chk("R10", "carry mid", {31'b0, carry_flag}, 32'h0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule